// File: doc/BRIEF.md
# Fetch Address Selector with Next-PC Prediction

This block supplies the address used to fetch an instruction in every cycle of a five-stage in-order pipeline (Fetch, Decode, Execute, Memory, Writeback). It holds a guessed next address in a register. The guess is formed from the instruction that has just been fetched. That instruction's class code arrives already decoded, together with its incremented address and its embedded constant.

Two later stages can overrule the guess. The first is a jump in the Memory stage whose condition turned out false: every jump is guessed taken, so its stored fall-through address becomes the fetch address. The second is a return in Writeback: the return target just loaded from memory becomes the fetch address. A return that is fetched makes no guess. The pipeline's hazard logic holds fetch through the fetch stall input until the return target is known.

Top module: `fpc_unit`

## Requirements
- R1: While reset (rst_n low at a clock edge) is applied, the prediction register loads address zero. With no correction active, fetch_pc then reads zero.
- R2: A fetched instruction of class CLS_OTHER (default 0) loads its incremented address (f_incr) into the prediction register at the next edge.
- R3: A fetched instruction of class CLS_CALL (default 2) loads its constant (f_const) into the prediction register at the next edge.
- R4: A fetched jump, class CLS_JUMP (default 1), is guessed taken and loads f_const into the prediction register, whatever its condition.
- R5: A fetched return, class CLS_RET (default 3), leaves the prediction register unchanged at the next edge.
- R6: When mem_cls is CLS_JUMP and mem_cond is 0, fetch_pc equals mem_fall in that same cycle.
- R7: A Memory-stage jump with mem_cond 1 does not redirect fetch. A Memory-stage instruction of any other class does not redirect fetch either, even with mem_cond 0.
- R8: When wb_cls is CLS_RET and no Memory-stage redirect is active, fetch_pc equals wb_load in that same cycle.
- R9: When the Memory-stage redirect and the Writeback return redirect occur together, fetch_pc equals mem_fall.
- R10: While fetch_stall is 1 at a clock edge, the prediction register keeps its value.
- R11: With no redirect active, fetch_pc equals pred_pc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_stall | input | 1 | Holds the prediction register |
| f_cls | input | CW | Class of the instruction fetched this cycle |
| f_incr | input | AW | Address following the fetched instruction |
| f_const | input | AW | Destination constant of the fetched instruction |
| mem_cls | input | CW | Class of the Memory-stage instruction |
| mem_cond | input | 1 | Condition outcome of the Memory-stage instruction |
| mem_fall | input | AW | Fall-through address carried in the Memory stage |
| wb_cls | input | CW | Class of the Writeback-stage instruction |
| wb_load | input | AW | Value loaded from memory, in Writeback |
| fetch_pc | output | AW | Address to fetch this cycle |
| pred_pc | output | AW | Registered predicted next address |

## Verification
Some properties are checked on every cycle: the stall hold and the return hold of the prediration register, the update rules for each class, and the redirect priority on fetch_pc. Only the bench's scenarios show certain results. These are a zero address on leaving reset, a taken Memory-stage jump or a non-jump class with a false condition causing no redirect, and a run of mixed classes that gives the right address from one cycle to the next.

// File: rtl/fpc_pkg.sv
// Shared defaults for the fetch address selector.
// Assumes class codes are already decoded upstream.
package fpc_pkg;
    localparam int DEF_AW = 32;
    localparam int DEF_CW = 2;
    localparam logic [DEF_CW-1:0] DEF_OTHER = 2'd0;
    localparam logic [DEF_CW-1:0] DEF_JUMP  = 2'd1;
    localparam logic [DEF_CW-1:0] DEF_CALL  = 2'd2;
    localparam logic [DEF_CW-1:0] DEF_RET   = 2'd3;
endpackage

// File: rtl/fpc_predict.sv
// Forms the guessed next address from the fetched instruction.
// Jumps are guessed taken; returns request no update of the register.
module fpc_predict #(
    parameter int AW = fpc_pkg::DEF_AW,
    parameter int CW = fpc_pkg::DEF_CW,
    parameter logic [CW-1:0] CLS_OTHER = fpc_pkg::DEF_OTHER,
    parameter logic [CW-1:0] CLS_JUMP  = fpc_pkg::DEF_JUMP,
    parameter logic [CW-1:0] CLS_CALL  = fpc_pkg::DEF_CALL,
    parameter logic [CW-1:0] CLS_RET   = fpc_pkg::DEF_RET
) (
    input  logic [CW-1:0] cls,
    input  logic [AW-1:0] incr,
    input  logic [AW-1:0] konst,
    output logic [AW-1:0] guess,
    output logic          guess_ok
);
    // Choose the guess by class of the fetched instruction.
    always_comb begin
        guess    = incr;
        guess_ok = 1'b1;
        if (cls == CLS_CALL || cls == CLS_JUMP) begin
            guess = konst;
        end else if (cls == CLS_RET) begin
            guess_ok = 1'b0;
        end else if (cls == CLS_OTHER) begin
            guess = incr;
        end
    end
endmodule

// File: rtl/fpc_select.sv
// Priority selector for the fetch address.
// A Memory-stage jump with a false condition outranks a Writeback return,
// and both outrank the registered guess.
module fpc_select #(
    parameter int AW = fpc_pkg::DEF_AW,
    parameter int CW = fpc_pkg::DEF_CW,
    parameter logic [CW-1:0] CLS_JUMP = fpc_pkg::DEF_JUMP,
    parameter logic [CW-1:0] CLS_RET  = fpc_pkg::DEF_RET
) (
    input  logic [CW-1:0] mem_cls,
    input  logic          mem_cond,
    input  logic [AW-1:0] mem_fall,
    input  logic [CW-1:0] wb_cls,
    input  logic [AW-1:0] wb_load,
    input  logic [AW-1:0] pred,
    output logic [AW-1:0] pc_out,
    output logic          mis_fix,
    output logic          ret_fix
);
    // Detect the two redirect conditions.
    always_comb begin
        mis_fix = (mem_cls == CLS_JUMP) && !mem_cond;
        ret_fix = (wb_cls == CLS_RET);
    end

    // Pick the fetch address by priority.
    always_comb begin
        if (mis_fix)      pc_out = mem_fall;
        else if (ret_fix) pc_out = wb_load;
        else              pc_out = pred;
    end
endmodule

// File: rtl/fpc_unit.sv
// Top of the fetch address selector: holds the prediction register and
// combines it with the later-stage redirects. Synchronous active-low reset.
module fpc_unit #(
    parameter int AW = fpc_pkg::DEF_AW,
    parameter int CW = fpc_pkg::DEF_CW,
    parameter logic [CW-1:0] CLS_OTHER = fpc_pkg::DEF_OTHER,
    parameter logic [CW-1:0] CLS_JUMP  = fpc_pkg::DEF_JUMP,
    parameter logic [CW-1:0] CLS_CALL  = fpc_pkg::DEF_CALL,
    parameter logic [CW-1:0] CLS_RET   = fpc_pkg::DEF_RET
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_stall,
    input  logic [CW-1:0] f_cls,
    input  logic [AW-1:0] f_incr,
    input  logic [AW-1:0] f_const,
    input  logic [CW-1:0] mem_cls,
    input  logic          mem_cond,
    input  logic [AW-1:0] mem_fall,
    input  logic [CW-1:0] wb_cls,
    input  logic [AW-1:0] wb_load,
    output logic [AW-1:0] fetch_pc,
    output logic [AW-1:0] pred_pc
);
    logic [AW-1:0] pred_q;
    logic [AW-1:0] guess;
    logic          guess_ok;
    logic          mis_fix;
    logic          ret_fix;
    logic          armed;

    fpc_predict #(.AW(AW), .CW(CW), .CLS_OTHER(CLS_OTHER), .CLS_JUMP(CLS_JUMP),
                  .CLS_CALL(CLS_CALL), .CLS_RET(CLS_RET)) predict_i (
        .cls(f_cls), .incr(f_incr), .konst(f_const),
        .guess(guess), .guess_ok(guess_ok)
    );

    fpc_select #(.AW(AW), .CW(CW), .CLS_JUMP(CLS_JUMP), .CLS_RET(CLS_RET)) select_i (
        .mem_cls(mem_cls), .mem_cond(mem_cond), .mem_fall(mem_fall),
        .wb_cls(wb_cls), .wb_load(wb_load), .pred(pred_q),
        .pc_out(fetch_pc), .mis_fix(mis_fix), .ret_fix(ret_fix)
    );

    // Prediction register: zero on reset, held on stall or return.
    always_ff @(posedge clk) begin
        if (!rst_n)                     pred_q <= '0;
        else if (!fetch_stall && guess_ok) pred_q <= guess;
    end

    // Marks that the previous edge was out of reset, for history checks.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assign pred_pc = pred_q;

    // R10: stall freezes the register.
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(fetch_stall) |-> $stable(pred_pc));
    // R5: a fetched return makes no guess.
    p_ret_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(f_cls == CLS_RET) |-> $stable(pred_pc));
    // R2: sequential instructions guess the incremented address.
    p_other_incr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(!fetch_stall && f_cls == CLS_OTHER) |-> pred_pc == $past(f_incr));
    // R3: calls guess the constant.
    p_call_const_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(!fetch_stall && f_cls == CLS_CALL) |-> pred_pc == $past(f_const));
    // R4: jumps guessed taken.
    p_jump_const_r4: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(!fetch_stall && f_cls == CLS_JUMP) |-> pred_pc == $past(f_const));
    // R6 and R9: a not-taken Memory jump wins.
    p_mis_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cls == CLS_JUMP && !mem_cond) |-> fetch_pc == mem_fall);
    // R8: the return target is used when no Memory redirect is present.
    p_ret_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cls == CLS_RET && !(mem_cls == CLS_JUMP && !mem_cond)) |-> fetch_pc == wb_load);
    // R11: otherwise the register drives the fetch address.
    p_pred_used_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mis_fix && !ret_fix) |-> fetch_pc == pred_pc);
endmodule

// File: tb/fpc_unit_tb_top.sv
module fpc_unit_tb_top;
    localparam int AW = 32;
    localparam logic [1:0] C_OTH = 2'd0, C_JMP = 2'd1, C_CALL = 2'd2, C_RET = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fetch_stall = 1'b0;
    logic [1:0] f_cls = C_OTH, mem_cls = C_OTH, wb_cls = C_OTH;
    logic [AW-1:0] f_incr = '0, f_const = '0, mem_fall = '0, wb_load = '0;
    logic mem_cond = 1'b0;
    logic [AW-1:0] fetch_pc, pred_pc;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    string         q_tag[$];
    logic [AW-1:0] q_fpc[$];
    logic [AW-1:0] q_pp[$];
    logic [AW-1:0] exp_pred = '0;

    always #5 clk = ~clk;

    fpc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_stall(fetch_stall),
        .f_cls(f_cls), .f_incr(f_incr), .f_const(f_const),
        .mem_cls(mem_cls), .mem_cond(mem_cond), .mem_fall(mem_fall),
        .wb_cls(wb_cls), .wb_load(wb_load),
        .fetch_pc(fetch_pc), .pred_pc(pred_pc)
    );

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the expected outputs.
    task automatic step(input string tag, input logic [1:0] fc, input logic [AW-1:0] fi,
                        input logic [AW-1:0] fk, input logic [1:0] mc, input logic mcond,
                        input logic [AW-1:0] mf, input logic [1:0] wc, input logic [AW-1:0] wl,
                        input logic st);
        logic [AW-1:0] efpc;
        @(negedge clk);
        f_cls = fc; f_incr = fi; f_const = fk; mem_cls = mc; mem_cond = mcond;
        mem_fall = mf; wb_cls = wc; wb_load = wl; fetch_stall = st;
        if (mc == C_JMP && !mcond) efpc = mf;
        else if (wc == C_RET)      efpc = wl;
        else                       efpc = exp_pred;
        q_tag.push_back(tag); q_fpc.push_back(efpc); q_pp.push_back(exp_pred);
        if (!st && fc != C_RET) exp_pred = (fc == C_OTH) ? fi : fk;
    endtask

    // Monitor: compare the queued expectations away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q_tag.size() > 0) begin
                string t;
                logic [AW-1:0] f, p;
                t = q_tag.pop_front(); f = q_fpc.pop_front(); p = q_pp.pop_front();
                check({t, " fetch_pc"}, fetch_pc, f);
                check({t, " pred_pc"}, pred_pc, p);
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset pred_pc", pred_pc, '0);
        check("R1 reset fetch_pc", fetch_pc, '0);
        rst_n = 1'b1;
        // R1: first cycle after reset still shows zero.
        step("R1 after reset", C_OTH, 32'h10, 32'h999, C_OTH, 1, 0, C_OTH, 0, 0);
        step("R2 other uses incr", C_CALL, 32'h14, 32'h200, C_OTH, 1, 0, C_OTH, 0, 0);
        step("R3 call uses const", C_JMP, 32'h204, 32'h300, C_OTH, 1, 0, C_OTH, 0, 0);
        step("R4 jump taken guess", C_RET, 32'h304, 32'h777, C_OTH, 1, 0, C_OTH, 0, 0);
        step("R5 return holds", C_OTH, 32'h500, 32'h0, C_OTH, 1, 0, C_OTH, 0, 1);
        step("R10 stall holds", C_JMP, 32'h600, 32'h640, C_OTH, 1, 0, C_OTH, 0, 0);
        step("R6 mispredict redirect", C_OTH, 32'h46, 32'h0, C_JMP, 0, 32'h44, C_OTH, 0, 0);
        step("R7 taken jump no redirect", C_OTH, 32'h4a, 32'h0, C_JMP, 1, 32'h55, C_OTH, 0, 0);
        step("R8 return redirect", C_OTH, 32'h8a, 32'h0, C_OTH, 1, 0, C_RET, 32'h88, 0);
        step("R9 mispredict beats return", C_CALL, 32'h90, 32'hA00, C_JMP, 0, 32'h66, C_RET, 32'h77, 0);
        step("R7 call in mem no redirect", C_OTH, 32'hA04, 32'h0, C_CALL, 0, 32'h12, C_OTH, 32'h34, 0);
        step("R11 quiet uses pred", C_RET, 32'h0, 32'h0, C_RET, 0, 32'h13, C_CALL, 32'h35, 1);
        step("R11 final", C_OTH, 32'h0, 32'h0, C_OTH, 1, 0, C_OTH, 0, 0);
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule